// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block arbitrates the interrupt requests of a small processor. Each of its sources owns a sticky pending flag, an enable bit and a three-bit priority. A non-maskable trap input sits above all of them. Every cycle the block finds the best eligible pending request and compares it with the priority level the processor is running at. It then presents a registered request with the winning vector number and that winner's level.

The processor accepts a request with an acknowledge strobe. The block then saves the running level on an internal level stack and raises the running level to the serviced level, so that only strictly more urgent work can preempt the handler. A return strobe pops the stack and restores the interrupted level. Pending flags are never cleared implicitly: a handler must strobe the per-source clear. A flag left set raises its request again as soon as the level allows it.

Top module: `irq_arbiter`

## Requirements
- R1: After reset, `irq_req` is 0, `cur_lvl` is 0, and every pending flag, including the trap flag, is clear.
- R2: A one-cycle pulse on `src_set[i]` sets flag i on the next edge. The flag stays set after the pulse ends. If the source is eligible, `irq_req` rises on the edge after the flag is set.
- R3: A source whose enable bit is 0, or whose priority field is 0, never produces a request.
- R4: A normal source is eligible only if its priority is strictly greater than `cur_lvl`. Equal or lower priorities wait.
- R5: Among eligible sources, the highest priority wins. On a tie, the source with the lowest index wins. The priority of source i is `src_prio[3*i+2:3*i]`.
- R6: A set trap flag ignores the enable and priority inputs and beats every source. It is presented as vector 0 at level 8. It is held back only while `cur_lvl` is 8.
- R7: An acknowledge while `irq_req` is 1 pushes `cur_lvl` and loads `cur_lvl` with `irq_lvl` on the same edge. It also forces `irq_req` to 0 on that edge. An acknowledge while `irq_req` is 0 has no effect.
- R8: A return strobe pops the level stack into `cur_lvl`. Levels come back in last-in, first-out order. A return with an empty stack leaves `cur_lvl` unchanged. If return and acknowledge arrive together, only the return takes effect.
- R9: Source i is reported as vector i+1. Vector 0 is reserved for the trap.
- R10: A pulse on `src_clr[i]` (or `trap_clr`) clears the flag on the next edge. If a set and a clear arrive in the same cycle, the set wins.
- R11: `irq_req`, `irq_vec` and `irq_lvl` are registered. A change of the enable or priority inputs shows on them one edge later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_set | input | N_SRC | Per-source event pulses that set flags |
| src_clr | input | N_SRC | Per-source flag clear strobes |
| src_en | input | N_SRC | Per-source enable bits |
| src_prio | input | 3*N_SRC | Packed three-bit priorities, source i at bits 3i+2:3i |
| trap_set | input | 1 | Non-maskable trap event pulse |
| trap_clr | input | 1 | Trap flag clear strobe |
| ack | input | 1 | Processor accepts the presented request |
| reti | input | 1 | Processor returns from the current handler |
| irq_req | output | 1 | Registered request to the processor |
| irq_vec | output | clog2(N_SRC+1) | Registered winning vector number |
| irq_lvl | output | 4 | Registered level of the winning request |
| cur_lvl | output | 4 | Running priority level |

## Verification
The bench sweeps every source through every priority with the enable bit on and off. This exposes a design that lets level 0 through, or one that ignores the enable bit. Priority patterns with paired ties target a wrong tie-break, such as a highest-index winner or an off-by-one vector. A climb through all eight nesting levels, ending in a trap, followed by eight returns, catches a stack that loses depth, restores in the wrong order or underflows on an extra return. Further cases cover:
- equal-level requests, which a design using greater-or-equal would let preempt;
- an acknowledge with no request, which must change nothing;
- simultaneous set and clear, where a lost event would drop the request.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int PRIO_W = 3;
  localparam int LVL_W  = PRIO_W + 1;
  localparam logic [LVL_W-1:0] TRAP_LVL = LVL_W'(1 << PRIO_W);

  function automatic logic [LVL_W-1:0] widen(input logic [PRIO_W-1:0] p);
    return {1'b0, p};
  endfunction

  // candidate beats both the running level and the best found so far
  function automatic logic outranks(input logic [LVL_W-1:0] cand,
                                    input logic [LVL_W-1:0] best,
                                    input logic [LVL_W-1:0] cur);
    return (cand != '0) && (cand > cur) && (cand > best);
  endfunction
endpackage

// File: rtl/irq_flags.sv
module irq_flags #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_o[g] <= 1'b0;
      else        flag_o[g] <= set_i[g] | (flag_o[g] & ~clr_i[g]);
    end

    // R2 R10
    set_sticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[g] |=> flag_o[g]);
    // R10
    clr_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[g] && !set_i[g]) |=> !flag_o[g]);
  end
endmodule

// File: rtl/irq_pick.sv
module irq_pick
  import irq_pkg::*;
#(
  parameter int N_SRC = 8,
  parameter int VEC_W = $clog2(N_SRC + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_SRC-1:0]        flag,
  input  logic [N_SRC-1:0]        en,
  input  logic [PRIO_W*N_SRC-1:0] prio,
  input  logic                    trap_flag,
  input  logic [LVL_W-1:0]        cur_lvl,
  output logic                    win_valid,
  output logic [VEC_W-1:0]        win_vec,
  output logic [LVL_W-1:0]        win_lvl
);
  logic [LVL_W-1:0] cand;

  always_comb begin
    win_valid = 1'b0;
    win_vec   = '0;
    win_lvl   = '0;
    cand      = '0;
    // ascending scan with strict compare keeps the lowest index on a tie
    for (int i = 0; i < N_SRC; i++) begin
      cand = widen(prio[i*PRIO_W +: PRIO_W]);
      if (flag[i] && en[i] && outranks(cand, win_lvl, cur_lvl)) begin
        win_valid = 1'b1;
        win_vec   = VEC_W'(i + 1);
        win_lvl   = cand;
      end
    end
    if (trap_flag && (cur_lvl < TRAP_LVL)) begin
      win_valid = 1'b1;
      win_vec   = '0;
      win_lvl   = TRAP_LVL;
    end
  end

  // R4
  above_cur_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> (win_lvl > cur_lvl));
  // R3
  masked_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> (win_lvl != '0));
endmodule

// File: rtl/irq_lvl_stack.sv
module irq_lvl_stack
  import irq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int SP_W  = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic [LVL_W-1:0] push_lvl,
  output logic             push_done,
  output logic [LVL_W-1:0] cur_lvl
);
  logic [LVL_W-1:0] mem [DEPTH];
  logic [SP_W-1:0]  sp;
  logic             empty, full, pop_done;

  assign empty     = (sp == '0);
  assign full      = (sp == SP_W'(DEPTH));
  assign pop_done  = pop & ~empty;
  assign push_done = push & ~pop & ~full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp      <= '0;
      cur_lvl <= '0;
    end else if (pop_done) begin
      cur_lvl <= mem[sp - SP_W'(1)];
      sp      <= sp - SP_W'(1);
    end else if (push_done) begin
      cur_lvl <= push_lvl;
      sp      <= sp + SP_W'(1);
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            mem[g] <= '0;
      else if (push_done && sp == SP_W'(g))  mem[g] <= cur_lvl;
    end
  end

  // R7
  push_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_done |=> (cur_lvl == $past(push_lvl)));
  // R8
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty) |=> $stable(cur_lvl));
  // R8
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sp <= SP_W'(DEPTH));
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
#(
  parameter int N_SRC     = 8,
  parameter int STK_DEPTH = 8,
  localparam int VEC_W    = $clog2(N_SRC + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_SRC-1:0]        src_set,
  input  logic [N_SRC-1:0]        src_clr,
  input  logic [N_SRC-1:0]        src_en,
  input  logic [PRIO_W*N_SRC-1:0] src_prio,
  input  logic                    trap_set,
  input  logic                    trap_clr,
  input  logic                    ack,
  input  logic                    reti,
  output logic                    irq_req,
  output logic [VEC_W-1:0]        irq_vec,
  output logic [LVL_W-1:0]        irq_lvl,
  output logic [LVL_W-1:0]        cur_lvl
);
  logic [N_SRC-1:0] flag;
  logic             trap_flag;
  logic             win_valid;
  logic [VEC_W-1:0] win_vec;
  logic [LVL_W-1:0] win_lvl;
  logic             ack_fire;
  logic             trap_pend;

  irq_flags #(.N(N_SRC)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_i(src_set), .clr_i(src_clr), .flag_o(flag));

  irq_flags #(.N(1)) u_trap (
    .clk(clk), .rst_n(rst_n), .set_i(trap_set), .clr_i(trap_clr), .flag_o(trap_flag));

  irq_pick #(.N_SRC(N_SRC), .VEC_W(VEC_W)) u_pick (
    .clk(clk), .rst_n(rst_n), .flag(flag), .en(src_en), .prio(src_prio),
    .trap_flag(trap_flag), .cur_lvl(cur_lvl),
    .win_valid(win_valid), .win_vec(win_vec), .win_lvl(win_lvl));

  irq_lvl_stack #(.DEPTH(STK_DEPTH)) u_stack (
    .clk(clk), .rst_n(rst_n), .push(ack & irq_req), .pop(reti),
    .push_lvl(irq_lvl), .push_done(ack_fire), .cur_lvl(cur_lvl));

  assign trap_pend = trap_flag && (cur_lvl < TRAP_LVL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_req <= 1'b0;
      irq_vec <= '0;
      irq_lvl <= '0;
    end else begin
      irq_req <= win_valid & ~ack_fire;
      irq_vec <= win_vec;
      irq_lvl <= win_lvl;
    end
  end

  // R6
  trap_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_pend && !ack_fire) |=> (irq_req && irq_vec == '0 && irq_lvl == TRAP_LVL));
  // R7
  ack_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_fire |=> !irq_req);
  // R9
  vec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_vec <= VEC_W'(N_SRC)));
  // R4
  req_above_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_lvl > cur_lvl));
endmodule

// File: tb/irq_arbiter_tb.sv
module irq_arbiter_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  src_set = '0, src_clr = '0, src_en = '0;
  logic [23:0] src_prio = '0;
  logic        trap_set = 1'b0, trap_clr = 1'b0, ack = 1'b0, reti = 1'b0;
  logic        irq_req;
  logic [3:0]  irq_vec, irq_lvl, cur_lvl;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irq_arbiter u_dut (
    .clk(clk), .rst_n(rst_n), .src_set(src_set), .src_clr(src_clr),
    .src_en(src_en), .src_prio(src_prio), .trap_set(trap_set),
    .trap_clr(trap_clr), .ack(ack), .reti(reti), .irq_req(irq_req),
    .irq_vec(irq_vec), .irq_lvl(irq_lvl), .cur_lvl(cur_lvl));

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // reference: scan levels downward, indices upward, first hit wins
  task automatic model(input logic [7:0] fl, input logic [7:0] en,
                       input logic [23:0] pr, input bit tr, input int cur,
                       output bit v, output int vec, output int lvl);
    v = 0; vec = 0; lvl = 0;
    if (tr && cur < 8) begin v = 1; vec = 0; lvl = 8; return; end
    for (int l = 7; l >= 1; l--) begin
      if (l <= cur) return;
      for (int i = 0; i < 8; i++)
        if (fl[i] && en[i] && int'(pr[i*3 +: 3]) == l) begin
          v = 1; vec = i + 1; lvl = l; return;
        end
    end
  endtask

  task automatic chk_out(string tag, bit ev, int evec, int elvl);
    chk({tag, " req"}, int'(irq_req), int'(ev));
    if (ev) begin
      chk({tag, " vec"}, int'(irq_vec), evec);
      chk({tag, " lvl"}, int'(irq_lvl), elvl);
    end
  endtask

  task automatic clear_all();
    src_clr = 8'hFF; trap_clr = 1'b1; src_en = '0; tick();
    src_clr = '0; trap_clr = 1'b0; tick();
  endtask

  task automatic do_ack();
    ack = 1'b1; tick(); ack = 1'b0;
  endtask

  task automatic do_reti();
    reti = 1'b1; tick(); reti = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit ev; int evec, elvl;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 req", int'(irq_req), 0);
    chk("R1 cur", int'(cur_lvl), 0);
    rst_n = 1'b1; tick();
    src_en = 8'hFF; src_prio = 24'hFFFFFF; tick(); tick();
    chk("R1 flags clear, no req", int'(irq_req), 0);

    // R7 ack with no request ignored
    do_ack(); tick();
    chk("R7 idle ack cur", int'(cur_lvl), 0);

    // R2 R3 R9: every source, every priority, enable on/off
    for (int s = 0; s < 8; s++)
      for (int p = 0; p < 8; p++)
        for (int e = 0; e < 2; e++) begin
          clear_all();
          src_prio = '0; src_prio[s*3 +: 3] = 3'(p);
          src_en = 8'(e) << s;
          src_set = 8'h01 << s; tick(); src_set = '0; tick();
          model(8'h01 << s, src_en, src_prio, 0, 0, ev, evec, elvl);
          chk_out("R2 R3 R9 sweep", ev, evec, elvl);
        end

    // R5 R11: ties and masks with all flags pending
    clear_all();
    src_set = 8'hFF; tick(); src_set = '0; tick();
    for (int k = 0; k < 8; k++) begin
      for (int i = 0; i < 8; i++) src_prio[i*3 +: 3] = 3'(((i >> 1) + k) % 8);
      src_en = 8'hFF ^ (8'h01 << k);
      tick();
      model(8'hFF, src_en, src_prio, 0, 0, ev, evec, elvl);
      chk_out("R5 R11 tie", ev, evec, elvl);
    end
    src_prio = 24'o33333333; src_en = 8'hFF; tick();
    chk_out("R5 all equal", 1, 1, 3);

    // R4 R7 R8 strict preemption
    clear_all();
    for (int i = 0; i < 8; i++) src_prio[i*3 +: 3] = 3'(i);
    src_set = 8'hFF; src_en = 8'h02; tick(); src_set = '0; tick();
    chk_out("R4 first", 1, 2, 1);
    do_ack();
    chk("R7 cur", int'(cur_lvl), 1);
    chk("R7 req drop", int'(irq_req), 0);
    src_en = 8'h0E; tick();
    chk_out("R4 R5 higher", 1, 4, 3);
    do_ack(); tick();
    chk("R7 cur3", int'(cur_lvl), 3);
    chk("R4 equal/lower wait", int'(irq_req), 0);
    src_en = 8'h1E; tick();
    chk_out("R4 above", 1, 5, 4);
    src_en = 8'h0E;
    do_reti(); tick();
    chk("R8 pop to 1", int'(cur_lvl), 1);
    chk_out("R8 restored req", 1, 4, 3);
    do_reti(); do_reti(); tick();
    chk("R8 empty pop", int'(cur_lvl), 0);

    // R10 set beats clear, then clear alone
    clear_all();
    src_prio = '0; src_prio[5*3 +: 3] = 3'd4; src_en = 8'h20;
    src_set = 8'h20; src_clr = 8'h20; tick(); src_set = '0; src_clr = '0; tick();
    chk_out("R10 set wins", 1, 6, 4);
    src_clr = 8'h20; tick(); src_clr = '0; tick();
    chk("R10 cleared", int'(irq_req), 0);

    // R6 R8 deep nesting with trap on top
    clear_all();
    for (int i = 0; i < 7; i++) src_prio[i*3 +: 3] = 3'(i + 1);
    src_prio[21 +: 3] = 3'd0;
    src_set = 8'h7F; tick(); src_set = '0; tick();
    for (int k = 0; k < 7; k++) begin
      src_en = 8'h01 << k; tick();
      chk_out("R8 climb", 1, k + 1, k + 1);
      do_ack();
      chk("R8 climb cur", int'(cur_lvl), k + 1);
    end
    src_en = 8'h7F;
    trap_set = 1'b1; tick(); trap_set = 1'b0; tick();
    chk_out("R6 trap", 1, 0, 8);
    do_ack(); tick();
    chk("R6 cur8", int'(cur_lvl), 8);
    chk("R6 trap held at 8", int'(irq_req), 0);
    for (int d = 7; d >= 0; d--) begin
      do_reti();
      chk("R8 lifo", int'(cur_lvl), d);
    end
    do_reti();
    chk("R8 underflow", int'(cur_lvl), 0);
    tick();
    chk_out("R6 trap again", 1, 0, 8);
    trap_clr = 1'b1; tick(); trap_clr = 1'b0; tick();
    chk_out("R6 R10 trap cleared", 1, 7, 7);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule